// File: doc/BRIEF.md
# Bit-Serial Lookup-Table FIR Filter

This block is a finite impulse response filter with coefficients fixed at elaboration. It has no multipliers. Every tap coefficient is a constant, so each sum of any subset of coefficients can be computed ahead of time and kept in a small table with one row per subset. A new sample is pushed into a tap delay line. The filter then walks the sample bits from least significant to most significant, one bit position per clock. At each position it collects that bit from every stored sample into a table address, and it folds the table row into an accumulator that shifts one place per cycle.

A sample is offered with a valid/ready handshake. The filter accepts it only while idle, and then stays busy for one cycle per sample bit. The full-precision filter output appears with a one-cycle valid strobe. Samples and coefficients are two's complement. The most significant bit slice carries negative weight, so its table row is subtracted rather than added. The tap count, the sample width, the coefficient width and the packed coefficient vector are parameters. The table is generated from the coefficient vector during elaboration.

Top module: `da_fir_serial`

## Requirements
- R1: While the synchronous reset is high, and in the cycle after it, `in_ready` is 1 and `out_valid` is 0. Reset empties the delay line, so the first result after reset depends only on the newest sample.
- R2: When `in_valid` is high while `in_ready` is low, the sample is dropped. The delay line and all later results are unchanged.
- R3: The result is presented exactly DW clock edges after the accepting edge, and `out_valid` is high for exactly one cycle.
- R4: `out_data` is the two's complement value sum over t of c[t]*x[n-t]. Coefficient c[t] occupies bits [t*CW +: CW] of `COEF_VEC`. x[n] is the newest sample, and samples before reset count as 0.
- R5: The output is OW = DW + CW + clog2(NTAPS) bits wide. The most negative sample and coefficient values are represented without overflow.
- R6: Each accepted sample moves the delay line by exactly one tap. Tap 0 holds the newest sample, and the oldest sample falls off the end.
- R7: `in_ready` is low from the cycle after acceptance until the result cycle. It is high in the result cycle and whenever the filter is idle.
- R8: A two-tap instance with table rows {0, c0, c1, c0+c1} gives c0 for the address pattern 01, c1 for 10 and c0+c1 for 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A sample is offered |
| in_data | input | DW | Sample, two's complement |
| in_ready | output | 1 | Filter idle; a sample can be taken |
| out_valid | output | 1 | One-cycle strobe: result ready |
| out_data | output | OW | Filter output, two's complement |

## Verification
The case hardest to reach from the ports is a sample offered while a pass is running. It must be ignored without disturbing the delay line. The stimulus keeps `in_valid` high with garbage data on random passes for the whole busy window. The expected values of all later outputs then expose any stray shift. Sign-slice subtraction at its extremes is reached with directed runs of the most negative sample, both on the four-tap instance and on a two-tap instance whose c0 is the most negative coefficient.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;

   typedef enum logic {
      FIR_IDLE = 1'b0,
      FIR_RUN  = 1'b1
   } fir_state_e;

   // width of any subset sum of ntaps signed coefficients of cw bits
   function automatic int subset_sum_width(input int cw, input int ntaps);
      return cw + $clog2(ntaps);
   endfunction

endpackage

// File: rtl/da_tap_line.sv
module da_tap_line #(
   parameter int NTAPS = 4,
   parameter int DW    = 8
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   shift_en,
   input  logic [DW-1:0]          din,
   output logic [NTAPS*DW-1:0]    taps_flat
);

   logic [DW-1:0] tap_q [NTAPS];

   for (genvar t = 0; t < NTAPS; t++) begin : g_tap
      if (t == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (rst)           tap_q[t] <= '0;
            else if (shift_en) tap_q[t] <= din;
         end
      end else begin : g_body
         always_ff @(posedge clk) begin
            if (rst)           tap_q[t] <= '0;
            else if (shift_en) tap_q[t] <= tap_q[t-1];
         end
      end
      assign taps_flat[t*DW +: DW] = tap_q[t];
   end

   // delay line must stay frozen unless a sample was accepted
   assert_hold_taps_R2: assert property (@(posedge clk) disable iff (rst)
      !shift_en |=> $stable(taps_flat))
      else $error("delay line moved without an accepted sample");

endmodule

// File: rtl/da_sum_table.sv
module da_sum_table #(
   parameter int                  NTAPS    = 4,
   parameter int                  CW       = 8,
   parameter int                  TW       = 10,
   parameter logic [NTAPS*CW-1:0] COEF_VEC = '0
) (
   input  logic [NTAPS-1:0]      addr,
   output logic signed [TW-1:0]  sum
);

   localparam int ROWS = 1 << NTAPS;

   function automatic logic signed [TW-1:0] row_value(input int a);
      logic signed [TW-1:0] acc;
      acc = '0;
      for (int t = 0; t < NTAPS; t++) begin
         if (((a >> t) & 1) == 1)
            acc = acc + TW'($signed(COEF_VEC[t*CW +: CW]));
      end
      return acc;
   endfunction

   logic signed [TW-1:0] rom [ROWS];

   for (genvar a = 0; a < ROWS; a++) begin : g_row
      assign rom[a] = row_value(a);
   end

   assign sum = rom[addr];

endmodule

// File: rtl/da_shift_acc.sv
module da_shift_acc #(
   parameter int TW = 10,
   parameter int DW = 8,
   parameter int IW = 3,
   parameter int OW = 18
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  clear,
   input  logic                  step,
   input  logic                  sign_slice,
   input  logic [IW-1:0]         bit_idx,
   input  logic signed [TW-1:0]  term,
   output logic [OW-1:0]         result
);

   localparam int HW = TW + 1;

   logic signed [HW-1:0] hi_q;
   logic [DW-2:0]        lo_q;
   logic signed [HW:0]   term_x;
   logic signed [HW:0]   s;
   logic signed [HW-1:0] hi_nxt;
   logic [OW:0]          full_nxt;

   always_comb begin
      term_x   = (HW+1)'(term);
      s        = $signed({hi_q[HW-1], hi_q}) + (sign_slice ? -term_x : term_x);
      hi_nxt   = s[HW:1];
      full_nxt = {hi_nxt, s[0], lo_q};
   end

   always_ff @(posedge clk) begin
      if (rst || clear) begin
         hi_q <= '0;
         lo_q <= '0;
      end else if (step) begin
         hi_q <= hi_nxt;
         if (!sign_slice) lo_q[bit_idx] <= s[0];
      end
   end

   assign result = full_nxt[OW-1:0];

   // the final sum must fit in OW bits: the spare top bit is a pure sign copy
   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
      (step && sign_slice) |-> (full_nxt[OW] == full_nxt[OW-1]))
      else $error("full-precision sum exceeds output width");

endmodule

// File: rtl/da_fir_serial.sv
module da_fir_serial
   import da_fir_pkg::*;
#(
   parameter int                  NTAPS    = 4,
   parameter int                  DW       = 8,
   parameter int                  CW       = 8,
   parameter logic [NTAPS*CW-1:0] COEF_VEC = 32'h0C07FB03,
   localparam int                 TW       = subset_sum_width(CW, NTAPS),
   localparam int                 OW       = DW + TW
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            in_valid,
   input  logic [DW-1:0]   in_data,
   output logic            in_ready,
   output logic            out_valid,
   output logic [OW-1:0]   out_data
);

   localparam int IW = $clog2(DW);

   if (NTAPS < 2 || NTAPS > 10) begin : g_bad_taps
      $error("NTAPS must lie in 2..10");
   end
   if (DW < 2) begin : g_bad_dw
      $error("DW must be at least 2");
   end
   if (CW < 2) begin : g_bad_cw
      $error("CW must be at least 2");
   end

   fir_state_e            st_q;
   logic [IW-1:0]         bit_q;
   logic                  accept;
   logic                  last;
   logic                  running;
   logic [NTAPS*DW-1:0]   taps_flat;
   logic [NTAPS-1:0]      slice_addr;
   logic signed [TW-1:0]  row_sum;
   logic [OW-1:0]         acc_result;

   assign in_ready = (st_q == FIR_IDLE);
   assign accept   = in_valid && in_ready;
   assign running  = (st_q == FIR_RUN);
   assign last     = (bit_q == IW'(DW-1));

   da_tap_line #(.NTAPS(NTAPS), .DW(DW)) u_taps (
      .clk      (clk),
      .rst      (rst),
      .shift_en (accept),
      .din      (in_data),
      .taps_flat(taps_flat)
   );

   // one bit position from every tap forms the table address
   for (genvar t = 0; t < NTAPS; t++) begin : g_slice
      assign slice_addr[t] = taps_flat[t*DW + int'(bit_q)];
   end

   da_sum_table #(.NTAPS(NTAPS), .CW(CW), .TW(TW), .COEF_VEC(COEF_VEC)) u_table (
      .addr(slice_addr),
      .sum (row_sum)
   );

   da_shift_acc #(.TW(TW), .DW(DW), .IW(IW), .OW(OW)) u_acc (
      .clk       (clk),
      .rst       (rst),
      .clear     (accept),
      .step      (running),
      .sign_slice(last),
      .bit_idx   (bit_q),
      .term      (row_sum),
      .result    (acc_result)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q      <= FIR_IDLE;
         bit_q     <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= 1'b0;
         if (accept) begin
            st_q  <= FIR_RUN;
            bit_q <= '0;
         end else if (running) begin
            if (last) begin
               st_q      <= FIR_IDLE;
               out_valid <= 1'b1;
               out_data  <= acc_result;
            end else begin
               bit_q <= bit_q + 1'b1;
            end
         end
      end
   end

   assert_reset_idle_R1: assert property (@(posedge clk)
      $past(rst) |-> (in_ready && !out_valid))
      else $error("not idle after reset");

   assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid)
      else $error("result strobe longer than one cycle");

   assert_bit_advance_R3: assert property (@(posedge clk) disable iff (rst)
      (running && !last) |=> (running && bit_q == IW'($past(bit_q) + 1'b1)))
      else $error("bit position skipped or pass cut short");

   assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (rst)
      accept |=> !in_ready)
      else $error("ready high right after acceptance");

   assert_ready_with_result_R7: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> in_ready)
      else $error("ready low while result presented");

endmodule

// File: tb/da_fir_serial_test.sv
`timescale 1ns/1ps
module da_fir_serial_test;

   localparam int NT = 4;
   localparam int DW = 8;
   localparam int CW = 8;
   localparam int OW = DW + CW + 2;
   localparam logic [NT*CW-1:0] CVEC = {8'sd12, 8'sd7, -8'sd5, 8'sd3};
   localparam int COEF [NT] = '{3, -5, 7, 12};

   // two-tap instance: c0 = -16 (most negative), c1 = 15
   localparam int P_DW = 6;
   localparam int P_CW = 5;
   localparam int P_OW = P_DW + P_CW + 1;
   localparam logic [2*P_CW-1:0] P_CVEC = {5'sd15, -5'sd16};

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic in_ready, out_valid;
   logic [OW-1:0] out_data;

   logic p_in_valid = 1'b0;
   logic [P_DW-1:0] p_in_data = '0;
   logic p_in_ready, p_out_valid;
   logic [P_OW-1:0] p_out_data;

   int checks = 0;
   int errors = 0;
   int hist [NT];
   int phist [2];
   bit done = 1'b0;

   always #5 clk = ~clk;

   da_fir_serial #(.NTAPS(NT), .DW(DW), .CW(CW), .COEF_VEC(CVEC)) uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data)
   );

   da_fir_serial #(.NTAPS(2), .DW(P_DW), .CW(P_CW), .COEF_VEC(P_CVEC)) uut_pair (
      .clk(clk), .rst(rst), .in_valid(p_in_valid), .in_data(p_in_data),
      .in_ready(p_in_ready), .out_valid(p_out_valid), .out_data(p_out_data)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic longint model_main();
      longint s = 0;
      for (int t = 0; t < NT; t++) s += longint'(COEF[t]) * longint'(hist[t]);
      return s;
   endfunction

   task automatic send_main(input int x, input bit poke, input string req);
      longint exp;
      bit early;
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = x[DW-1:0];
      check(in_ready == 1'b1, "R7 ready while idle", longint'(in_ready), 1);
      @(posedge clk);
      for (int t = NT-1; t > 0; t--) hist[t] = hist[t-1];
      hist[0] = x;
      exp = model_main();
      @(negedge clk);
      in_valid = poke;
      in_data  = DW'($urandom);
      check(!in_ready, "R7 ready low during pass", longint'(in_ready), 0);
      early = out_valid;
      for (int i = 1; i < DW; i++) begin
         @(negedge clk);
         early = early | out_valid | in_ready;
      end
      check(!early, "R3/R7 early strobe or ready inside pass", longint'(early), 0);
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid == 1'b1, "R3 strobe after DW edges", longint'(out_valid), 1);
      check(longint'($signed(out_data)) == exp, req, longint'($signed(out_data)), exp);
      @(negedge clk);
      check(out_valid == 1'b0, "R3 single-cycle strobe", longint'(out_valid), 0);
   endtask

   task automatic send_pair(input int x);
      longint exp;
      @(negedge clk);
      p_in_valid = 1'b1;
      p_in_data  = x[P_DW-1:0];
      @(posedge clk);
      phist[1] = phist[0];
      phist[0] = x;
      exp = -16 * longint'(phist[0]) + 15 * longint'(phist[1]);
      @(negedge clk);
      p_in_valid = 1'b0;
      repeat (P_DW) @(negedge clk);
      check(p_out_valid == 1'b1, "R8 two-tap strobe", longint'(p_out_valid), 1);
      check(longint'($signed(p_out_data)) == exp, "R8 two-tap table row",
            longint'($signed(p_out_data)), exp);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      in_valid = 1'b0;
      p_in_valid = 1'b0;
      @(negedge clk);
      check(in_ready && !out_valid, "R1 idle during reset",
            longint'({in_ready, out_valid}), 2);
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check(in_ready && !out_valid, "R1 idle after reset",
            longint'({in_ready, out_valid}), 2);
      foreach (hist[t]) hist[t] = 0;
      phist[0] = 0;
      phist[1] = 0;
   endtask

   initial begin
      void'($urandom(32'd2024));
      foreach (hist[t]) hist[t] = 0;
      phist[0] = 0;
      phist[1] = 0;
      repeat (3) @(negedge clk);
      do_reset();

      // impulse walks down the taps: 3, -5, 7, 12, then 0
      send_main(1, 1'b0, "R1 first result uses newest sample only");
      send_main(0, 1'b0, "R6 impulse at tap 1");
      send_main(0, 1'b0, "R6 impulse at tap 2");
      send_main(0, 1'b0, "R6 impulse at tap 3");
      send_main(0, 1'b0, "R6 impulse leaves the line");

      // extremes of the sign slice
      for (int k = 0; k < NT; k++) send_main(-128, 1'b0, "R5 most negative samples");
      for (int k = 0; k < NT; k++) send_main(127, 1'b0, "R5 most positive samples");
      send_main(-128, 1'b1, "R2 offer during pass ignored");
      send_main(-1, 1'b1, "R2 offer during pass ignored");

      // random mix
      for (int n = 0; n < 200; n++) begin
         int x = int'($urandom_range(255)) - 128;
         bit poke = 1'(($urandom % 4) == 0);
         send_main(x, poke, poke ? "R2/R4 random sample with busy offer" : "R4 random sample");
         repeat ($urandom % 3) @(negedge clk);
      end

      // reset in the middle of a history
      send_main(77, 1'b0, "R4 before mid reset");
      do_reset();
      send_main(5, 1'b0, "R1 line cleared by reset");

      // two-tap rows: 01 -> c0, 10 -> c1, 11 -> c0+c1
      send_pair(1);
      send_pair(0);
      send_pair(1);
      send_pair(1);
      send_pair(-32);
      send_pair(-32);
      send_pair(31);

      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule